// File: doc/BRIEF.md
# Receive Character Queue with Timeout Interrupt

This block sits between a serial receiver and the host. Each character the receiver completes is pushed into a 64-deep queue together with its three error tags (parity, framing, break). The oldest entry is always visible as the holding register, with its own tags beside it. When the host reads the holding register, the queue advances, and the next entry's byte and tags appear together.

The block requests service in one of two ways. In immediate mode it requests service as soon as any character is waiting. In threshold mode it waits until the fill level reaches a programmed level. Data left below that level would otherwise wait forever, so a timeout also requests service. The timeout counts bit-time ticks while the queue holds data. It restarts whenever a character arrives or the host reads. Its span is four character lengths plus twelve bit times, where one character is a start bit, the configured data bits and one stop bit.

A character that arrives while the queue is full is dropped, and a sticky overrun flag is set. A status read clears that flag.

Top module: `rx_char_queue`

## Requirements
- R1: The queue holds up to 64 entries in arrival order. `head_data` shows the oldest stored byte.
- R2: Each byte carries its 3-bit tag word `{break, framing, parity}` (bit 2 down to bit 0). `head_tags` always belongs to the byte on `head_data`. After a host read, both switch to the next entry from the next cycle on.
- R3: `data_ready` is high exactly while the queue holds at least one entry. A host read of an empty queue changes nothing.
- R4: With `cfg_thresh_mode`=0, the level condition holds whenever the queue is non-empty.
- R5: With `cfg_thresh_mode`=1, the level condition holds when the fill level is at least `cfg_thresh` (legal range 1 to 64).
- R6: `irq` equals `cfg_rx_ie` AND (level condition OR `tmo_flag`). With `cfg_rx_ie`=0, `irq` stays low.
- R7: `cfg_wlen` selects 5+`cfg_wlen` data bits. Counted bit ticks are those seen while the queue is non-empty and nothing arrives or is read. `tmo_flag` rises in the cycle after the (4*(7+`cfg_wlen`)+12)-th counted tick: 40 ticks for `cfg_wlen`=0 and 52 for `cfg_wlen`=3.
- R8: Any arriving character or accepted host read clears the tick count and drops `tmo_flag`. Ticks have no effect while the queue is empty.
- R9: A character that arrives while the queue is full is discarded, even if a host read happens in the same cycle. `overrun` then goes high on the next cycle.
- R10: `overrun` stays high until `stat_rd`. If a new overrun and `stat_rd` happen in the same cycle, the overrun wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Receiver delivers one character |
| wr_data | input | 8 | Received byte |
| wr_tags | input | 3 | Error tags {break, framing, parity} |
| rd_en | input | 1 | Host reads the holding register |
| stat_rd | input | 1 | Host reads status; clears overrun |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_thresh_mode | input | 1 | 0: immediate, 1: threshold |
| cfg_thresh | input | 7 | Threshold fill level |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| bit_tick | input | 1 | One pulse per bit time |
| head_data | output | 8 | Oldest stored byte |
| head_tags | output | 3 | Tags of the oldest byte |
| data_ready | output | 1 | Queue non-empty |
| tmo_flag | output | 1 | Character timeout pending |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receive interrupt |

## Verification
A corrupted read or write pointer shows on `head_data` and `head_tags` at the very next read: the bench compares every dequeued byte and tag word against the order in which they were pushed. A wrong fill count shows as `data_ready` dropping early or late while the queue is drained, or as the threshold interrupt firing one character off. A timeout counter that is off by one, misses its restart, or runs on an empty queue moves the rise of `tmo_flag` by at least one tick. The bench probes the tick just before the limit and the tick at the limit, so such an error shows within one bit time.

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int TW    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic [TW-1:0]                wr_tags,
  input  logic                         rd_en,
  input  logic                         stat_rd,
  input  logic [1:0]                   cfg_wlen,
  input  logic                         cfg_thresh_mode,
  input  logic [$clog2(DEPTH):0]       cfg_thresh,
  input  logic                         cfg_rx_ie,
  input  logic                         bit_tick,
  output logic [DW-1:0]                head_data,
  output logic [TW-1:0]                head_tags,
  output logic                         data_ready,
  output logic                         tmo_flag,
  output logic                         overrun,
  output logic                         irq
);
  localparam int AW    = $clog2(DEPTH);
  localparam int EW    = DW + TW;
  localparam int TMAX  = 4 * (7 + 3) + 12;
  localparam int CW    = $clog2(TMAX + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic [CW-1:0] tcnt;
  logic [CW-1:0] tlimit;

  wire empty = (count == '0);
  wire full  = (count == (AW+1)'(DEPTH));
  wire push  = wr_en && !full;
  wire pop   = rd_en && !empty;

  assign tlimit = CW'(40) + CW'({cfg_wlen, 2'b00});

  assign {head_data, head_tags} = mem[rp];
  assign data_ready = !empty;

  wire lvl_hit = !empty && (!cfg_thresh_mode || count >= cfg_thresh);
  assign irq = cfg_rx_ie && (lvl_hit || tmo_flag);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_data, wr_tags};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt     <= '0;
      tmo_flag <= 1'b0;
    end else if (wr_en || pop || empty) begin
      tcnt     <= '0;
      tmo_flag <= 1'b0;
    end else if (bit_tick && !tmo_flag) begin
      if (tcnt == tlimit - 1'b1) begin
        tcnt     <= '0;
        tmo_flag <= 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              overrun <= 1'b0;
    else if (wr_en && full)  overrun <= 1'b1;
    else if (stat_rd)        overrun <= 1'b0;
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

  // R3
  first_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && empty) |=> data_ready);

  // R3
  last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && count == 1) |=> !data_ready);

  // R9
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (full && overrun));

  // R10
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !stat_rd) |=> overrun);

  // R10
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(wr_en && full)) |=> !overrun);

  // R7
  tmo_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |-> data_ready);

  // R8
  tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |=> !tmo_flag);
endmodule

// File: tb/rx_char_queue_bench.sv
module rx_char_queue_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0, rd_en = 0, stat_rd = 0, bit_tick = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_tags = 0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_thresh_mode = 0, cfg_rx_ie = 1;
  logic [6:0] cfg_thresh = 7'd1;
  logic [7:0] head_data;
  logic [2:0] head_tags;
  logic       data_ready, tmo_flag, overrun, irq;
  int         total = 0, failed = 0;

  always #2 clk = ~clk;

  rx_char_queue u_rx_char_queue (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_tags(wr_tags),
    .rd_en(rd_en), .stat_rd(stat_rd), .cfg_wlen(cfg_wlen),
    .cfg_thresh_mode(cfg_thresh_mode), .cfg_thresh(cfg_thresh), .cfg_rx_ie(cfg_rx_ie),
    .bit_tick(bit_tick), .head_data(head_data), .head_tags(head_tags),
    .data_ready(data_ready), .tmo_flag(tmo_flag), .overrun(overrun), .irq(irq));

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] t);
    @(negedge clk); wr_en = 1; wr_data = d; wr_tags = t;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pop();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
  endtask

  task automatic drain();
    while (data_ready) pop();
  endtask

  task automatic t_reset();
    chk("R3 reset data_ready", data_ready, 0);
    chk("R6 reset irq", irq, 0);
    chk("R10 reset overrun", overrun, 0);
    chk("R7 reset tmo_flag", tmo_flag, 0);
  endtask

  task automatic t_order();
    cfg_thresh_mode = 0; cfg_rx_ie = 1;
    pop();
    chk("R3 empty read ignored", data_ready, 0);
    push(8'h11, 3'b001); push(8'h22, 3'b010); push(8'h33, 3'b100);
    chk("R1 head first", head_data, 8'h11);
    chk("R2 tags first", head_tags, 3'b001);
    chk("R4 immediate irq", irq, 1);
    pop();
    chk("R1 head second", head_data, 8'h22);
    chk("R2 tags second", head_tags, 3'b010);
    pop();
    chk("R2 tags third", head_tags, 3'b100);
    cfg_rx_ie = 0;
    @(negedge clk);
    chk("R6 disabled irq", irq, 0);
    cfg_rx_ie = 1;
    pop();
    chk("R3 drained", data_ready, 0);
  endtask

  task automatic t_thresh();
    cfg_thresh_mode = 1; cfg_thresh = 7'd4;
    push(8'h01, 0); push(8'h02, 0); push(8'h03, 0);
    chk("R5 below threshold", irq, 0);
    chk("R3 ready below threshold", data_ready, 1);
    push(8'h04, 0);
    chk("R5 at threshold", irq, 1);
    pop();
    chk("R5 back below", irq, 0);
    drain();
  endtask

  task automatic t_timeout();
    cfg_thresh_mode = 1; cfg_thresh = 7'd8; cfg_wlen = 2'd3;
    push(8'hA0, 0); push(8'hA1, 0);
    ticks(51);
    chk("R7 tick 51 of 52", tmo_flag, 0);
    ticks(1);
    chk("R7 tick 52 of 52", tmo_flag, 1);
    chk("R6 irq from timeout", irq, 1);
    pop();
    chk("R8 read drops timeout", tmo_flag, 0);
    ticks(51);
    chk("R8 restart after read 51", tmo_flag, 0);
    ticks(1);
    chk("R8 restart after read 52", tmo_flag, 1);
    pop();
    ticks(60);
    chk("R8 empty no timeout", tmo_flag, 0);
    push(8'hB0, 0);
    ticks(30);
    push(8'hB1, 0);
    ticks(30);
    chk("R8 arrival restarts count", tmo_flag, 0);
    ticks(22);
    chk("R8 timeout after arrival", tmo_flag, 1);
    drain();
    cfg_wlen = 2'd0;
    push(8'hC0, 0);
    ticks(39);
    chk("R7 wlen0 tick 39", tmo_flag, 0);
    ticks(1);
    chk("R7 wlen0 tick 40", tmo_flag, 1);
    drain();
    cfg_wlen = 2'd3;
  endtask

  task automatic t_full();
    int bad = 0;
    cfg_thresh_mode = 1; cfg_thresh = 7'd64;
    for (int i = 0; i < 64; i++) push(8'(i), 3'(i));
    chk("R5 threshold 64", irq, 1);
    chk("R10 no overrun yet", overrun, 0);
    push(8'hEE, 3'b111);
    chk("R9 overrun set", overrun, 1);
    chk("R9 head kept", head_data, 0);
    @(negedge clk); wr_en = 1; wr_data = 8'hDD; rd_en = 1;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R9 drop with read head", head_data, 1);
    for (int i = 1; i < 64; i++) begin
      if (head_data != 8'(i) || head_tags != 3'(i) || !data_ready) bad++;
      pop();
    end
    chk("R1 64-entry order", bad, 0);
    chk("R9 nothing extra stored", data_ready, 0);
    chk("R10 overrun sticky", overrun, 1);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk("R10 status read clears", overrun, 0);
  endtask

  initial begin
    #400000;
    failed++; total++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_thresh();
    t_timeout();
    t_full();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule